// File: doc/BRIEF.md
# Multi-mode fixed-point rounding unit

This block takes a fixed-point word with a configurable number of integer and fraction bits and rounds it to an integer-valued code in the same format. After rounding, every fraction bit of the result is zero. A 3-bit mode input picks one of six rounding rules per operand. A parameter chooses whether the word is read as two's complement or as unsigned. The datapath uses only one increment path on the integer field, plus a few tests on the fraction. It has no decrementer and no widened intermediate. Incrementing the largest integer code does not wrap: the result saturates.

One optional output register, enabled by a parameter, gives a single cycle of latency. A valid bit travels alongside the data. The register loads only on cycles where the input valid is high, and it keeps its value otherwise. Two degenerate formats are handled at elaboration time. A format with no fraction bits passes the operand straight through. A format with no integer bits always yields zero.

Top module: `fxp_round_unit`

## Requirements
- R1: Mode code 0 (floor) clears the fraction bits and leaves the integer field unchanged, so a signed operand rounds toward minus infinity.
- R2: Mode code 1 (ceil) adds one to the integer field whenever any fraction bit is 1, and otherwise leaves it unchanged.
- R3: Mode code 2 (toward zero) adds one to the integer field only when the operand is negative and its fraction is non-zero. For unsigned operands this mode is plain truncation.
- R4: Mode code 3 (round) adds one when the fraction is at least one half, so ties go toward plus infinity.
- R5: Mode code 4 (nearest) rounds to the nearest integer, with ties going away from zero. For unsigned operands it increments exactly when the top fraction bit is 1.
- R6: Mode code 5 (convergent) adds one when the fraction is above one half. On an exact half it adds one only if the integer LSB is 1, so ties land on the even neighbour.
- R7: Mode codes 6 and 7 behave exactly as floor.
- R8: Every fraction bit position of the output is 0, and the output width equals the input width.
- R9: An increment applied to the largest integer code (0111…1 signed, 11…1 unsigned) keeps that code instead of wrapping.
- R10: With zero fraction bits, the output equals the input in every mode.
- R11: With zero integer bits, the output is zero in every mode.
- R12: With the pipeline enabled, out_valid equals in_valid from the previous cycle. A low rst_n sampled at a clock edge clears out_valid.
- R13: While in_valid is low, out_data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand valid; loads the output register |
| in_data | input | INT_W+FRAC_W | Operand, integer field in the upper bits |
| mode | input | 3 | Rounding rule select (codes in R1–R7) |
| out_valid | output | 1 | Result valid |
| out_data | output | INT_W+FRAC_W | Rounded result, fraction bits zero |

## Verification
The signed default format is swept over every 12-bit operand in all eight mode codes. This pass separates modes that differ only on exact halves (round, nearest and convergent) from modes that differ only in the sign of a non-zero fraction (ceil and toward zero). A hand-worked table pins down the tie cases on both sides of zero, even and odd integer LSBs, and ceil at the largest code. Separate unsigned, fraction-less and integer-less instances show that the sign test drops out, and that the degenerate formats pass through or give zero. Directed sequences cover holding the result while in_valid is low and clearing out_valid on reset.

// File: rtl/fxr_pkg.sv
// Package: shared mode encoding for the rounding unit.
// Assumes the 3-bit mode bus; unlisted codes fall back to floor.
package fxr_pkg;
    typedef enum logic [2:0] {
        RM_FLOOR   = 3'd0,
        RM_CEIL    = 3'd1,
        RM_ZERO    = 3'd2,
        RM_ROUND   = 3'd3,
        RM_NEAREST = 3'd4,
        RM_CONV    = 3'd5
    } rmode_e;
endpackage

// File: rtl/fxr_decide.sv
// Increment decision: from the fraction, the sign and the integer LSB,
// decides whether the integer field must be bumped by one.
// Assumes FRAC_W >= 1 and INT_W >= 1 (the degenerate cases are handled above).
module fxr_decide #(
    parameter int FRAC_W      = 4,
    parameter bit SIGNED_MODE = 1'b1
) (
    input  logic [FRAC_W-1:0] frac,
    input  logic              sign_bit,
    input  logic              int_lsb,
    input  logic [2:0]        mode,
    output logic              inc
);
    import fxr_pkg::*;

    logic frac_nz;
    logic top_bit;
    logic low_nz;
    logic neg;
    logic gt_half;
    logic eq_half;

    // Any bit below the top fraction bit set?
    generate
        if (FRAC_W > 1) begin : g_low
            assign low_nz = |frac[FRAC_W-2:0];
        end else begin : g_nolow
            assign low_nz = 1'b0;
        end
    endgenerate

    // Compare the fraction against one half without an adder.
    always_comb begin
        frac_nz = |frac;
        top_bit = frac[FRAC_W-1];
        neg     = SIGNED_MODE && sign_bit;
        gt_half = top_bit && low_nz;
        eq_half = top_bit && !low_nz;
    end

    // Select the increment rule for the requested mode.
    always_comb begin
        case (rmode_e'(mode))
            RM_CEIL:    inc = frac_nz;
            RM_ZERO:    inc = neg && frac_nz;
            RM_ROUND:   inc = top_bit;
            RM_NEAREST: inc = neg ? gt_half : top_bit;
            RM_CONV:    inc = gt_half || (eq_half && int_lsb);
            default:    inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/fxr_incsat.sv
// Saturating incrementer on the integer field: adds the decision bit,
// keeping the largest representable integer code instead of wrapping.
// Assumes INT_W >= 1.
module fxr_incsat #(
    parameter int INT_W       = 8,
    parameter bit SIGNED_MODE = 1'b1
) (
    input  logic [INT_W-1:0] int_in,
    input  logic             inc,
    output logic [INT_W-1:0] int_out
);
    localparam logic [INT_W-1:0] MAX_CODE = {INT_W{1'b1}} >> (SIGNED_MODE ? 1 : 0);

    // Bump unless already at the top code.
    always_comb begin
        if (inc && (int_in != MAX_CODE)) int_out = int_in + INT_W'(1);
        else                             int_out = int_in;
    end
endmodule

// File: rtl/fxr_stage.sv
// Optional output register with valid; transparent when PIPELINE is 0.
// Data loads only with in_valid; valid clears on synchronous active-low reset.
module fxr_stage #(
    parameter int W        = 12,
    parameter bit PIPELINE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic         out_valid,
    output logic [W-1:0] q
);
    generate
        if (PIPELINE) begin : g_reg
            // Track the valid bit one cycle behind the input.
            always_ff @(posedge clk) begin
                if (!rst_n) out_valid <= 1'b0;
                else        out_valid <= in_valid;
            end
            // Capture the rounded word on accepted operands only.
            always_ff @(posedge clk) begin
                if (in_valid) q <= d;
            end
        end else begin : g_wire
            assign out_valid = in_valid;
            assign q         = d;
        end
    endgenerate
endmodule

// File: rtl/fxp_round_unit.sv
// Multi-mode fixed-point rounding unit.
// Operand layout: integer field in the top INT_W bits, fraction in the low
// FRAC_W bits. Result keeps the layout with a zero fraction. Formats with no
// fraction bits pass through; formats with no integer bits give zero.
module fxp_round_unit #(
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 4,
    parameter bit SIGNED_MODE = 1'b1,
    parameter bit PIPELINE    = 1'b1,
    localparam int W          = INT_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic [2:0]   mode,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [W-1:0] rounded;

    generate
        if (FRAC_W == 0) begin : g_nofrac
            assign rounded = in_data;
        end else if (INT_W == 0) begin : g_noint
            assign rounded = '0;
        end else begin : g_core
            logic [INT_W-1:0]  int_f;
            logic [FRAC_W-1:0] frac_f;
            logic [INT_W-1:0]  int_r;
            logic              bump;

            assign int_f  = in_data[W-1:FRAC_W];
            assign frac_f = in_data[FRAC_W-1:0];

            fxr_decide #(.FRAC_W(FRAC_W), .SIGNED_MODE(SIGNED_MODE)) u_decide (
                .frac     (frac_f),
                .sign_bit (int_f[INT_W-1]),
                .int_lsb  (int_f[0]),
                .mode     (mode),
                .inc      (bump)
            );

            fxr_incsat #(.INT_W(INT_W), .SIGNED_MODE(SIGNED_MODE)) u_incsat (
                .int_in  (int_f),
                .inc     (bump),
                .int_out (int_r)
            );

            assign rounded = {int_r, {FRAC_W{1'b0}}};
        end
    endgenerate

    fxr_stage #(.W(W), .PIPELINE(PIPELINE)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (rounded),
        .out_valid (out_valid),
        .q         (out_data)
    );
endmodule

// File: rtl/fxr_round_chk.sv
// Checker for fxp_round_unit: port-level properties, bound to every instance.
module fxr_round_chk #(
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 4,
    parameter bit SIGNED_MODE = 1'b1,
    parameter bit PIPELINE    = 1'b1,
    localparam int W          = INT_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic [2:0]   mode,
    input logic         out_valid,
    input logic [W-1:0] out_data
);
    localparam logic [W-1:0] ONE_INT  = W'(1) << FRAC_W;
    localparam logic [W-1:0] FMASK    = ONE_INT - W'(1);
    localparam logic [W-1:0] MAX_CODE = ({W{1'b1}} >> (SIGNED_MODE ? 1 : 0)) & ~FMASK;

    // R8
    frac_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & FMASK) == '0));

    generate
        if (PIPELINE) begin : g_seq
            // R12
            valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid == $past(in_valid)));
            // R13
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_data));
            // R1
            floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 3'd0) |=> (out_data == ($past(in_data) & ~FMASK)));
            // R9
            no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> ((out_data == ($past(in_data) & ~FMASK)) ||
                              ((out_data == (($past(in_data) & ~FMASK) + ONE_INT)) &&
                               (($past(in_data) & ~FMASK) != MAX_CODE))));
            if (FRAC_W == 0) begin : g_pass
                // R10
                pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid |=> (out_data == $past(in_data)));
            end
        end
        if (INT_W == 0) begin : g_zero
            // R11
            zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_data == '0));
        end
    endgenerate
endmodule

bind fxp_round_unit fxr_round_chk #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .SIGNED_MODE(SIGNED_MODE), .PIPELINE(PIPELINE)
) u_round_chk (.*);

// File: tb/fxp_round_unit_bench.sv
// Bench: hand-worked vector table, exhaustive sweep against a
// reference model, then directed tests for unsigned, degenerate formats,
// hold and reset.
module fxp_round_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [11:0] a_in = '0, a_out;
    logic [7:0]  u_in = '0, u_out;
    logic [5:0]  p_in = '0, p_out;
    logic [4:0]  z_in = '0, z_out;
    logic        a_ov, u_ov, p_ov, z_ov;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fxp_round_unit #(.INT_W(8), .FRAC_W(4), .SIGNED_MODE(1'b1)) u_fxp_round_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(a_in), .mode(mode),
        .out_valid(a_ov), .out_data(a_out));
    fxp_round_unit #(.INT_W(4), .FRAC_W(4), .SIGNED_MODE(1'b0)) u_fxp_round_unit_uns (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(u_in), .mode(mode),
        .out_valid(u_ov), .out_data(u_out));
    fxp_round_unit #(.INT_W(6), .FRAC_W(0), .SIGNED_MODE(1'b1)) u_fxp_round_unit_nofrac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(p_in), .mode(mode),
        .out_valid(p_ov), .out_data(p_out));
    fxp_round_unit #(.INT_W(0), .FRAC_W(5), .SIGNED_MODE(1'b1)) u_fxp_round_unit_noint (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(z_in), .mode(mode),
        .out_valid(z_ov), .out_data(z_out));

    // {mode, operand, expected}; signed Q8.4
    localparam int NV = 20;
    localparam logic [26:0] VEC [NV] = '{
        {3'd0, 12'h028, 12'h020},   // R1  2.5 -> 2
        {3'd0, 12'hFD8, 12'hFD0},   // R1 -2.5 -> -3
        {3'd1, 12'h024, 12'h030},   // R2  2.25 -> 3
        {3'd1, 12'h030, 12'h030},   // R2  3.0 -> 3
        {3'd1, 12'hFD8, 12'hFE0},   // R2 -2.5 -> -2
        {3'd2, 12'hFD8, 12'hFE0},   // R3 -2.5 -> -2
        {3'd2, 12'h02C, 12'h020},   // R3  2.75 -> 2
        {3'd3, 12'hFD8, 12'hFE0},   // R4 -2.5 -> -2
        {3'd3, 12'h028, 12'h030},   // R4  2.5 -> 3
        {3'd4, 12'hFD8, 12'hFD0},   // R5 -2.5 -> -3
        {3'd4, 12'h028, 12'h030},   // R5  2.5 -> 3
        {3'd4, 12'hFD9, 12'hFE0},   // R5 -2.4375 -> -2
        {3'd5, 12'h028, 12'h020},   // R6  2.5 -> 2
        {3'd5, 12'h038, 12'h040},   // R6  3.5 -> 4
        {3'd5, 12'h029, 12'h030},   // R6  2.5625 -> 3
        {3'd5, 12'hFC8, 12'hFC0},   // R6 -3.5 -> -4
        {3'd1, 12'h7F8, 12'h7F0},   // R9 127.5 ceil -> 127
        {3'd6, 12'h028, 12'h020},   // R7 code 6 = floor
        {3'd7, 12'hFD8, 12'hFD0},   // R7 code 7 = floor
        {3'd3, 12'h800, 12'h800}    // R4 -128 stays
    };

    function automatic string tag_of(input int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference: value v in sixteenths, result in the same encoding.
    function automatic logic [11:0] ref_main(input int m, input int v);
        int q, r, res;
        q = v >>> 4;
        r = v - q * 16;
        case (m)
            1: res = q + ((r != 0) ? 1 : 0);
            2: res = q + ((v < 0 && r != 0) ? 1 : 0);
            3: res = q + ((r >= 8) ? 1 : 0);
            4: res = q + ((v < 0) ? ((r > 8) ? 1 : 0) : ((r >= 8) ? 1 : 0));
            5: res = q + ((r > 8 || (r == 8 && (q % 2 != 0))) ? 1 : 0);
            default: res = q;
        endcase
        if (res > 127) res = 127;   // R9
        return 12'(res * 16);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [11:0] a, input logic [7:0] u,
                         input logic [5:0] p, input logic [4:0] z);
        @(negedge clk);
        mode = m; a_in = a; u_in = u; p_in = p; z_in = z; in_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset valid", {31'd0, a_ov}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][26:24], VEC[i][23:12], 8'h00, 6'h00, 5'h00);
            check($sformatf("%s vec%0d", tag_of(int'(VEC[i][26:24])), i), {20'd0, a_out}, {20'd0, VEC[i][11:0]});
            check("R8 frac zero", {28'd0, a_out[3:0]}, 32'd0);
        end

        // R1..R7, R10, R11 exhaustive sweep
        for (int m = 0; m < 8; m++) begin
            for (int v = -2048; v < 2048; v++) begin
                apply(3'(m), 12'(v), 8'h00, 6'(v), 5'(v));
                check(tag_of(m), {20'd0, a_out}, {20'd0, ref_main(m, v)});
                check("R10 pass", {26'd0, p_out}, {26'd0, 6'(v)});
                check("R11 zero", {27'd0, z_out}, 32'd0);
            end
        end

        // unsigned Q4.4
        apply(3'd2, 12'h0, 8'hFF, 6'h0, 5'h0);
        check("R3 unsigned trunc", {24'd0, u_out}, 32'h0F0);
        apply(3'd4, 12'h0, 8'h27, 6'h0, 5'h0);
        check("R5 unsigned below half", {24'd0, u_out}, 32'h020);
        apply(3'd4, 12'h0, 8'h28, 6'h0, 5'h0);
        check("R5 unsigned half", {24'd0, u_out}, 32'h030);
        apply(3'd5, 12'h0, 8'h18, 6'h0, 5'h0);
        check("R6 unsigned tie odd", {24'd0, u_out}, 32'h020);
        apply(3'd4, 12'h0, 8'hF8, 6'h0, 5'h0);
        check("R9 unsigned saturate", {24'd0, u_out}, 32'h0F0);
        apply(3'd1, 12'h0, 8'hF1, 6'h0, 5'h0);
        check("R9 unsigned ceil top", {24'd0, u_out}, 32'h0F0);

        // R13 hold while in_valid low
        apply(3'd3, 12'h028, 8'h00, 6'h00, 5'h00);
        @(negedge clk);
        in_valid = 1'b0; a_in = 12'h7F8; mode = 3'd1;
        repeat (3) @(negedge clk);
        check("R13 hold", {20'd0, a_out}, 32'h030);
        check("R12 valid low", {31'd0, a_ov}, 32'd0);

        // R12 reset clears valid
        apply(3'd0, 12'h050, 8'h00, 6'h00, 5'h00);
        check("R12 valid high", {31'd0, a_ov}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset clears", {31'd0, a_ov}, 32'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule